// File: doc/BRIEF.md
# Host bridge control register file

This block is the register front end of a host-to-PCI bridge, seen from the CPU as a 32-bit memory-mapped window. It holds the bridge's own 256-byte configuration header, a configuration address register, a memory base register and an I/O base register. It also has a data port. A CPU access to the data port becomes one indirect 4-byte configuration transaction on a simple request/acknowledge bus, and the transaction goes to the address held in the configuration address register.

The I/O base register places a 256 KiB I/O window in the system address space. The block decodes every system address against that window and gives a hit flag and the offset inside the window. Four device interrupt requests are each tagged with a device number, and each drives the interrupt line whose index equals that number.

The CPU side holds `req_valid` and its fields steady until `resp_valid` pulses. Every access other than one to the data port completes one cycle after it is accepted. A data-port access waits until the configuration bus acknowledges.

Top module: `hb_regfile`

## Requirements
- R1: After reset the header word at offset 0x004 reads 0x02900080. This is the command half with wait-cycle control (0x0080), and the status half with capability list, fast back-to-back and medium select timing (0x0290). All other header words read 0. The configuration address and memory base registers read 0, and the I/O base register reads 0xFE240000.
- R2: Aligned accesses to offsets 0x000 to 0x0FC write and read back header word offset/4 as a full 32-bit value.
- R3: Offset 0x1C0 (configuration address) stores every written bit and reads it back unchanged.
- R4: Offset 0x1C4 (memory base) stores only the written bits under mask 0xFF000001 and reads the stored value.
- R5: Offset 0x1C8 (I/O base) takes a write only if bits [31:18] of the written value differ from the stored bits [31:18]. In that case it stores the value ANDed with 0xFFFC0001. Otherwise the whole write, bit 0 included, is dropped.
- R6: `io_base` equals I/O base bits [31:18] followed by 18 zero bits. `io_hit` is 1 exactly when `sys_addr[31:18]` equals those bits. `io_offset` is `sys_addr[17:0]`.
- R7: A write to offset 0x220 raises `cfg_req` with `cfg_we`=1, `cfg_addr` = configuration address register and `cfg_wdata` = write data. These hold until `cfg_ack`. `resp_valid` stays low until the cycle after the acknowledge.
- R8: A read of offset 0x220 raises `cfg_req` with `cfg_we`=0 and returns the `cfg_rdata` value present with `cfg_ack`.
- R9: Unaligned addresses (bits [1:0] not 00) and offsets outside the mapped ones read 0, and writes to them change no register and start no configuration transaction.
- R10: `irq_out[k]` is the OR of every `irq_in[i]` whose device number `irq_dev[5*i+4:5*i]` equals k. Device numbers of 4 or more drive no line.
- R11: An access that is not to the data port gets a single-cycle `resp_valid` in the cycle after acceptance, carrying its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU access request, held until resp_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| cfg_req | output | 1 | Configuration transaction request |
| cfg_we | output | 1 | Configuration write (1) or read (0) |
| cfg_addr | output | 32 | Configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration acknowledge |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| sys_addr | input | 32 | System address to decode |
| io_hit | output | 1 | sys_addr falls in the I/O window |
| io_offset | output | 18 | Offset of sys_addr within the window |
| io_base | output | 32 | Start of the I/O window |
| irq_in | input | 4 | Device interrupt requests |
| irq_dev | input | 20 | Device number of each request, 5 bits each |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
The I/O base register is driven with writes that keep the upper bits and change only bit 0 or the masked bits. A design that compared the whole value, or left out the mask, would move the window or set bit 0 when it should not. The bench sweeps every unmapped word offset and several unaligned aliases of live registers and of the data port. It then reads back the live state and counts configuration requests, so a decoder that ignored bits [1:0] or aliased the upper space would either corrupt a register or issue a stray transaction. The configuration target acknowledges after 0 to 3 wait cycles. A design that answered the CPU early, or took read data before the acknowledge, would return the wrong word or complete too soon. All sixteen interrupt patterns are tried under several device-number maps, including out-of-range numbers, to catch lines that are swapped or wrongly ORed.

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int ADDR_W    = 10,
  parameter int HDR_WORDS = 64,
  parameter int NIRQ      = 4,
  parameter int DEV_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   resp_valid,
  output logic [31:0]            resp_rdata,
  output logic                   cfg_req,
  output logic                   cfg_we,
  output logic [31:0]            cfg_addr,
  output logic [31:0]            cfg_wdata,
  input  logic                   cfg_ack,
  input  logic [31:0]            cfg_rdata,
  input  logic [31:0]            sys_addr,
  output logic                   io_hit,
  output logic [17:0]            io_offset,
  output logic [31:0]            io_base,
  input  logic [NIRQ-1:0]        irq_in,
  input  logic [NIRQ*DEV_W-1:0]  irq_dev,
  output logic [NIRQ-1:0]        irq_out
);
  localparam int HDR_AW = $clog2(HDR_WORDS);
  localparam logic [ADDR_W-1:0] OFS_CADDR = ADDR_W'(10'h1C0);
  localparam logic [ADDR_W-1:0] OFS_MBASE = ADDR_W'(10'h1C4);
  localparam logic [ADDR_W-1:0] OFS_IBASE = ADDR_W'(10'h1C8);
  localparam logic [ADDR_W-1:0] OFS_DPORT = ADDR_W'(10'h220);
  localparam logic [31:0] MBASE_MASK = 32'hFF00_0001;
  localparam logic [31:0] IBASE_MASK = 32'hFFFC_0001;
  localparam logic [31:0] IBASE_RST  = 32'hFE24_0000;
  localparam logic [31:0] HDR1_RST   = 32'h0290_0080;

  logic [31:0] hdr [HDR_WORDS];
  logic [31:0] caddr, mbase, ibase;
  logic        pend;
  logic [31:0] rd_mux;

  wire accept  = req_valid && !resp_valid && !pend;
  wire aligned = (req_addr[1:0] == 2'b00);
  wire in_hdr  = aligned && (req_addr[ADDR_W-1:HDR_AW+2] == '0);
  wire [HDR_AW-1:0] widx = req_addr[HDR_AW+1:2];
  wire is_dport = aligned && (req_addr == OFS_DPORT);

  always_comb begin
    rd_mux = '0;
    if (in_hdr) rd_mux = hdr[widx];
    else if (aligned) begin
      case (req_addr)
        OFS_CADDR: rd_mux = caddr;
        OFS_MBASE: rd_mux = mbase;
        OFS_IBASE: rd_mux = ibase;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_WORDS; i++) hdr[i] <= (i == 1) ? HDR1_RST : '0;
      caddr <= '0;
      mbase <= '0;
      ibase <= IBASE_RST;
    end else if (accept && req_write) begin
      if (in_hdr) hdr[widx] <= req_wdata;
      else if (aligned) begin
        case (req_addr)
          OFS_CADDR: caddr <= req_wdata;
          OFS_MBASE: mbase <= req_wdata & MBASE_MASK;
          OFS_IBASE:
            if (req_wdata[31:18] != ibase[31:18]) ibase <= req_wdata & IBASE_MASK;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      cfg_req    <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_addr   <= '0;
      cfg_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (pend) begin
        if (cfg_ack) begin
          pend       <= 1'b0;
          cfg_req    <= 1'b0;
          resp_valid <= 1'b1;
          resp_rdata <= cfg_we ? '0 : cfg_rdata;
        end
      end else if (accept) begin
        if (is_dport) begin
          pend      <= 1'b1;
          cfg_req   <= 1'b1;
          cfg_we    <= req_write;
          cfg_addr  <= caddr;
          cfg_wdata <= req_wdata;
        end else begin
          resp_valid <= 1'b1;
          resp_rdata <= req_write ? '0 : rd_mux;
        end
      end
    end
  end

  assign io_base   = {ibase[31:18], 18'b0};
  assign io_hit    = (sys_addr[31:18] == ibase[31:18]);
  assign io_offset = sys_addr[17:0];

  always_comb begin
    irq_out = '0;
    for (int k = 0; k < NIRQ; k++)
      for (int i = 0; i < NIRQ; i++)
        if (irq_in[i] && (irq_dev[i*DEV_W +: DEV_W] == DEV_W'(k))) irq_out[k] = 1'b1;
  end

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req);
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_we));
  a_r7_no_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !resp_valid);
  a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_req_from_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(req_valid));
  a_r5_ibase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(io_base));
endmodule

// File: tb/hb_regfile_bench.sv
module hb_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [9:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic resp_valid;
  logic [31:0] resp_rdata;
  logic cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;
  logic [31:0] sys_addr = 0;
  logic io_hit;
  logic [17:0] io_offset;
  logic [31:0] io_base;
  logic [3:0] irq_in = 0;
  logic [19:0] irq_dev = 0;
  logic [3:0] irq_out;

  int checks = 0, fails = 0;
  int cfg_count = 0, cfg_delay = 0;
  logic [31:0] last_caddr, last_cdata;
  logic last_cwe;
  int last_wait;
  localparam logic [31:0] RKEY = 32'h5A5A_C3C3;

  always #5 clk = ~clk;

  hb_regfile u_hb_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
    .cfg_rdata(cfg_rdata), .sys_addr(sys_addr), .io_hit(io_hit),
    .io_offset(io_offset), .io_base(io_base), .irq_in(irq_in),
    .irq_dev(irq_dev), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req && !cfg_ack) begin
        cfg_count++;
        last_caddr = cfg_addr; last_cdata = cfg_wdata; last_cwe = cfg_we;
        for (int d = 0; d < cfg_delay; d++) @(negedge clk);
        cfg_rdata = cfg_addr ^ RKEY;
        cfg_ack = 1;
        @(negedge clk);
        cfg_ack = 0;
        cfg_rdata = 0;
      end
    end
  end

  task automatic access(input logic wr, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      n++;
    end while (!resp_valid && n < 50);
    rd = resp_rdata;
    last_wait = n;
    req_valid = 0;
    if (!resp_valid) chk("R11 response timeout", 0, 1);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    logic [31:0] x;
    access(1, a, d, x);
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    access(0, a, 0, v);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bad, cnt0;
    logic [3:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg_req at reset", {31'b0, cfg_req}, 0);
    chk("R1 resp_valid at reset", {31'b0, resp_valid}, 0);
    chk("R1 io_base at reset", io_base, 32'hFE24_0000);

    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(10'(i*4), v);
      if (v !== ((i == 1) ? 32'h0290_0080 : 32'h0)) bad++;
    end
    chk("R1 header reset words wrong", bad, 0);
    rd(10'h1C0, v); chk("R1 caddr reset", v, 0);
    rd(10'h1C4, v); chk("R1 mbase reset", v, 0);
    rd(10'h1C8, v); chk("R1 ibase reset", v, 32'hFE24_0000);
    chk("R11 single-cycle response", last_wait, 1);
    @(negedge clk); chk("R11 pulse drops", {31'b0, resp_valid}, 0);

    for (int i = 0; i < 64; i++) wr(10'(i*4), (32'(i) * 32'h0101_0101) ^ 32'hDEAD_0000);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(10'(i*4), v);
      if (v !== ((32'(i) * 32'h0101_0101) ^ 32'hDEAD_0000)) bad++;
    end
    chk("R2 header write/read mismatches", bad, 0);

    wr(10'h1C0, 32'hFFFF_FFFF); rd(10'h1C0, v); chk("R3 caddr all ones", v, 32'hFFFF_FFFF);
    wr(10'h1C0, 32'h8000_1234); rd(10'h1C0, v); chk("R3 caddr pattern", v, 32'h8000_1234);

    wr(10'h1C4, 32'hFFFF_FFFF); rd(10'h1C4, v); chk("R4 mbase mask", v, 32'hFF00_0001);
    wr(10'h1C4, 32'h1234_5678); rd(10'h1C4, v); chk("R4 mbase pattern", v, 32'h1234_5678 & 32'hFF00_0001);

    wr(10'h1C8, 32'hFE24_FFFF); rd(10'h1C8, v); chk("R5 same upper ignored", v, 32'hFE24_0000);
    wr(10'h1C8, 32'h1234_5679); rd(10'h1C8, v); chk("R5 masked store", v, 32'h1234_5679 & 32'hFFFC_0001);
    wr(10'h1C8, 32'h1234_0000); rd(10'h1C8, v); chk("R5 bit0 kept when upper same", v, 32'h1234_0001);
    wr(10'h1C8, 32'h1237_0000); rd(10'h1C8, v); chk("R5 bits17:16 dropped", v, 32'h1234_0001);
    wr(10'h1C8, 32'h1238_0000); rd(10'h1C8, v); chk("R5 bit18 change taken", v, 32'h1238_0000);

    chk("R6 io_base", io_base, 32'h1238_0000);
    bad = 0;
    for (int u = 0; u < 16384; u++) begin
      sys_addr = {14'(u), 18'(u * 7 + 3)};
      #1;
      if (io_hit !== (14'(u) == 14'(32'h1238_0000 >> 18))) bad++;
      if (io_offset !== 18'(u * 7 + 3)) bad++;
    end
    chk("R6 window decode mismatches", bad, 0);
    sys_addr = 32'h1238_0000; #1; chk("R6 first byte hit", {31'b0, io_hit}, 1);
    sys_addr = 32'h123B_FFFF; #1; chk("R6 last byte hit", {31'b0, io_hit}, 1);
    sys_addr = 32'h123C_0000; #1; chk("R6 past end miss", {31'b0, io_hit}, 0);

    for (int d = 0; d < 4; d++) begin
      cfg_delay = d;
      wr(10'h1C0, 32'h8000_0810 + 32'(d*4));
      cnt0 = cfg_count;
      wr(10'h220, 32'hCAFE_F00D ^ 32'(d));
      chk("R7 one transaction", cfg_count - cnt0, 1);
      chk("R7 cfg write flag", {31'b0, last_cwe}, 1);
      chk("R7 cfg address", last_caddr, 32'h8000_0810 + 32'(d*4));
      chk("R7 cfg data", last_cdata, 32'hCAFE_F00D ^ 32'(d));
      chk("R7 response after ack", last_wait, d + 2);
      wr(10'h1C0, 32'h8001_0000 + 32'(d*256));
      rd(10'h220, v);
      chk("R8 cfg read flag", {31'b0, last_cwe}, 0);
      chk("R8 cfg read data", v, (32'h8001_0000 + 32'(d*256)) ^ RKEY);
    end
    cfg_delay = 0;

    cnt0 = cfg_count;
    for (int a = 64; a < 256; a++)
      if (a != 10'h1C0/4 && a != 10'h1C4/4 && a != 10'h1C8/4 && a != 10'h220/4)
        wr(10'(a*4), 32'hFFFF_FFFF);
    wr(10'h1C1, 32'h0000_0000);
    wr(10'h1C6, 32'h0000_0000);
    wr(10'h1CB, 32'h0000_0000);
    wr(10'h005, 32'h0000_0000);
    wr(10'h221, 32'h0000_0000);
    rd(10'h222, v); chk("R9 unaligned data port reads 0", v, 0);
    chk("R9 no stray cfg transaction", cfg_count - cnt0, 0);
    bad = 0;
    for (int a = 64; a < 256; a++)
      if (a != 10'h1C0/4 && a != 10'h1C4/4 && a != 10'h1C8/4 && a != 10'h220/4) begin
        rd(10'(a*4), v);
        if (v !== 0) bad++;
      end
    chk("R9 unmapped reads nonzero", bad, 0);
    rd(10'h1C3, v); chk("R9 unaligned read 0", v, 0);
    rd(10'h1C0, v); chk("R9 caddr untouched", v, 32'h8001_0300);
    rd(10'h1C4, v); chk("R9 mbase untouched", v, 32'h1200_0000);
    rd(10'h1C8, v); chk("R9 ibase untouched", v, 32'h1238_0000);
    rd(10'h004, v); chk("R9 header untouched", v, 32'h0101_0101 ^ 32'hDEAD_0000);

    bad = 0;
    for (int m = 0; m < 4; m++) begin
      logic [4:0] dn [4];
      for (int i = 0; i < 4; i++)
        case (m)
          0: dn[i] = 5'(i);
          1: dn[i] = 5'(3 - i);
          2: dn[i] = 5'(i % 2);
          default: dn[i] = (i < 2) ? 5'(i + 4) : 5'(2);
        endcase
      irq_dev = {dn[3], dn[2], dn[1], dn[0]};
      for (int p = 0; p < 16; p++) begin
        irq_in = 4'(p);
        e = 0;
        for (int i = 0; i < 4; i++)
          if (p[i] && dn[i] < 4) e[dn[i][1:0]] = 1'b1;
        #1;
        if (irq_out !== e) bad++;
      end
    end
    chk("R10 irq routing mismatches", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule